// File: doc/BRIEF.md
# Paired-Register Barrel Shift Unit

This unit executes the 16-bit register shift group of a processor's 0xE opcode space. It takes the opcode and a valid strobe. It drives the read addresses of the destination register, the source register and the neighbouring pair register, and receives their contents from an outside register file. The destination value is shifted by the low five bits of the source value. The result comes back through up to two write ports one clock later.

Two of the shift types are plain logical shifts, one to the left and one to the right. The other two are "or" variants that chain the low register of the pair to the high one. The left variant runs on the low register: the bits pushed out of its top are ORed into the next register up. The right variant runs on the high register: the bits pushed out of its bottom are ORed into the next register down. Two such instructions in a row therefore shift a 32-bit value held in the pair.

The arithmetic and rotate types are decoded but flagged unimplemented. So is an "or" variant aimed at any register other than its pair member. Opcodes outside the group are left alone for other units.

Top module: `pair_shift_unit`

## Requirements
- R1: An opcode belongs to the group only when (op & 0xF188) == 0xE108. On a strobe with any other opcode the unit asserts no write enable and no unimplemented flag in the following cycle.
- R2: Type op[6:4]=2 is a logical left shift. It writes register op[11:9] on port 0 with (Rd << amt) truncated to 16 bits. amt is rs_data[4:0]; the upper source bits are ignored. Amounts 16 to 31 yield 0.
- R3: Type op[6:4]=4 is a logical right shift. It writes register op[11:9] on port 0 with Rd >> amt. Amounts 16 to 31 yield 0.
- R4: Type 3 with Rd = R3 forms the 32-bit value Rd << amt. It writes the low half to R3 on port 0 and writes (old R4 | high half) to R4 on port 1 in the same cycle. nb_addr_o reads 4 during this opcode.
- R5: Type 5 with Rd = R4 forms the 32-bit value (Rd << 16) >> amt. It writes the high half to R4 on port 0 and writes (old R3 | low half) to R3 on port 1 in the same cycle. nb_addr_o reads 3 during this opcode.
- R6: Type 3 with Rd other than R3, and type 5 with Rd other than R4, raise the unimplemented flag and write no register.
- R7: Types 0, 1, 6 and 7 raise the unimplemented flag and write no register.
- R8: Write enables and the flag appear exactly one cycle after the strobe. A cycle without the strobe is followed by a cycle with no write enable and no flag.
- R9: While reset is asserted, all registered outputs are 0.
- R10: The read addresses follow the opcode combinationally. rd_addr_o is op[11:9] and rs_addr_o is op[2:0]. nb_addr_o is Rd-1 for type 5 and Rd+1 for every other type, modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Opcode strobe |
| op_i | input | 16 | Opcode |
| rd_addr_o | output | 3 | Destination register read address |
| rs_addr_o | output | 3 | Source register read address |
| nb_addr_o | output | 3 | Neighbour register read address |
| rd_data_i | input | 16 | Destination register contents |
| rs_data_i | input | 16 | Source register contents |
| nb_data_i | input | 16 | Neighbour register contents |
| wr0_en_o | output | 1 | Primary write enable |
| wr0_addr_o | output | 3 | Primary write address |
| wr0_data_o | output | 16 | Primary write data |
| wr1_en_o | output | 1 | Neighbour write enable |
| wr1_addr_o | output | 3 | Neighbour write address |
| wr1_data_o | output | 16 | Neighbour write data |
| unimpl_o | output | 1 | Unimplemented opcode flag |

## Verification
The bench builds the unit with its defaults: 16-bit data, a 5-bit amount and the pair at R3/R4. The full sweep stays small at that size. It covers every shift type against every destination register and every amount from 0 to 31, with three data patterns for each. Under this sweep, the out-of-range amounts from 16 to 31 and every misplaced "or" variant are exercised. The bench also flips each bit of the group mask on an opcode to confirm that the opcode is rejected.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  typedef enum logic [2:0] {
    SH_ASR   = 3'd0,
    SH_ASROR = 3'd1,
    SH_LSL   = 3'd2,
    SH_LSLOR = 3'd3,
    SH_LSR   = 3'd4,
    SH_LSROR = 3'd5,
    SH_ROL   = 3'd6,
    SH_ROR   = 3'd7
  } sh_kind_e;

  localparam logic [15:0] GRP_MASK  = 16'hF188;
  localparam logic [15:0] GRP_MATCH = 16'hE108;
endpackage

// File: rtl/pshift_decode.sv
module pshift_decode
  import pshift_pkg::*;
#(
  parameter int PAIR_LO = 3
) (
  input  logic [15:0] op_i,
  output logic        hit_o,
  output sh_kind_e    kind_o,
  output logic [2:0]  rd_o,
  output logic [2:0]  rs_o,
  output logic [2:0]  nb_o,
  output logic        left_o,
  output logic        wr0_o,
  output logic        wr1_o,
  output logic        unimpl_o
);
  localparam logic [2:0] PairLo = 3'(PAIR_LO);
  localparam logic [2:0] PairHi = 3'(PAIR_LO + 1);

  assign hit_o  = (op_i & GRP_MASK) == GRP_MATCH;
  assign kind_o = sh_kind_e'(op_i[6:4]);
  assign rd_o   = op_i[11:9];
  assign rs_o   = op_i[2:0];
  assign nb_o   = (kind_o == SH_LSROR) ? rd_o - 3'd1 : rd_o + 3'd1;
  assign left_o = (kind_o == SH_LSL) || (kind_o == SH_LSLOR);

  always_comb begin
    wr0_o    = 1'b0;
    wr1_o    = 1'b0;
    unimpl_o = 1'b0;
    if (hit_o) begin
      unique case (kind_o)
        SH_LSL, SH_LSR: wr0_o = 1'b1;
        SH_LSLOR: begin
          wr0_o    = (rd_o == PairLo);
          wr1_o    = (rd_o == PairLo);
          unimpl_o = (rd_o != PairLo);
        end
        SH_LSROR: begin
          wr0_o    = (rd_o == PairHi);
          wr1_o    = (rd_o == PairHi);
          unimpl_o = (rd_o != PairHi);
        end
        default: unimpl_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pshift_barrel.sv
module pshift_barrel #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 5
) (
  input  logic [DATA_W-1:0]   data_i,
  input  logic [AMT_W-1:0]    amt_i,
  input  logic                left_i,
  output logic [2*DATA_W-1:0] wide_o
);
  localparam int WW = 2 * DATA_W;

  logic [WW-1:0] stg [AMT_W+1];

  // left: value sits in the low half; right: value sits in the high half
  assign stg[0] = left_i ? {{DATA_W{1'b0}}, data_i} : {data_i, {DATA_W{1'b0}}};

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = !amt_i[k] ? stg[k] :
                      left_i    ? (stg[k] << SH) : (stg[k] >> SH);
  end

  assign wide_o = stg[AMT_W];
endmodule

// File: rtl/pair_shift_unit.sv
module pair_shift_unit
  import pshift_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int AMT_W   = 5,
  parameter int PAIR_LO = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       op_i,
  output logic [2:0]        rd_addr_o,
  output logic [2:0]        rs_addr_o,
  output logic [2:0]        nb_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [DATA_W-1:0] rs_data_i,
  input  logic [DATA_W-1:0] nb_data_i,
  output logic              wr0_en_o,
  output logic [2:0]        wr0_addr_o,
  output logic [DATA_W-1:0] wr0_data_o,
  output logic              wr1_en_o,
  output logic [2:0]        wr1_addr_o,
  output logic [DATA_W-1:0] wr1_data_o,
  output logic              unimpl_o
);
  logic        hit, left, dec_wr0, dec_wr1, dec_unimpl;
  sh_kind_e    kind;
  logic [2:0]  rd_idx, rs_idx, nb_idx;
  logic [2*DATA_W-1:0] wide;
  logic [DATA_W-1:0]   lo_half, hi_half, w0_data, w1_data;

  pshift_decode #(.PAIR_LO(PAIR_LO)) u_dec (
    .op_i     (op_i),
    .hit_o    (hit),
    .kind_o   (kind),
    .rd_o     (rd_idx),
    .rs_o     (rs_idx),
    .nb_o     (nb_idx),
    .left_o   (left),
    .wr0_o    (dec_wr0),
    .wr1_o    (dec_wr1),
    .unimpl_o (dec_unimpl)
  );

  pshift_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_bsh (
    .data_i (rd_data_i),
    .amt_i  (rs_data_i[AMT_W-1:0]),
    .left_i (left),
    .wide_o (wide)
  );

  assign rd_addr_o = rd_idx;
  assign rs_addr_o = rs_idx;
  assign nb_addr_o = nb_idx;

  assign lo_half = wide[DATA_W-1:0];
  assign hi_half = wide[2*DATA_W-1:DATA_W];
  assign w0_data = left ? lo_half : hi_half;
  // spilled bits merge into the old neighbour value
  assign w1_data = nb_data_i | (left ? hi_half : lo_half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr0_en_o   <= 1'b0;
      wr0_addr_o <= '0;
      wr0_data_o <= '0;
      wr1_en_o   <= 1'b0;
      wr1_addr_o <= '0;
      wr1_data_o <= '0;
      unimpl_o   <= 1'b0;
    end else begin
      wr0_en_o   <= valid_i && dec_wr0;
      wr1_en_o   <= valid_i && dec_wr1;
      unimpl_o   <= valid_i && dec_unimpl;
      wr0_addr_o <= rd_idx;
      wr0_data_o <= w0_data;
      wr1_addr_o <= nb_idx;
      wr1_data_o <= w1_data;
    end
  end

  logic unused_kind;
  assign unused_kind = ^{kind, hit, rs_data_i};
endmodule

// File: rtl/pshift_chk.sv
module pshift_chk #(
  parameter int DATA_W  = 16,
  parameter int PAIR_LO = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [15:0]       op_i,
  input logic [DATA_W-1:0] rs_data_i,
  input logic              wr0_en_o,
  input logic [2:0]        wr0_addr_o,
  input logic [DATA_W-1:0] wr0_data_o,
  input logic              wr1_en_o,
  input logic [2:0]        wr1_addr_o,
  input logic              unimpl_o
);
  logic grp;
  assign grp = (op_i & 16'hF188) == 16'hE108;

  p_foreign_op_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !grp) |=> (!wr0_en_o && !wr1_en_o && !unimpl_o));

  p_lsl_far_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp && op_i[6:4] == 3'd2 && rs_data_i[4]) |=> (wr0_en_o && wr0_data_o == '0));

  p_lsr_far_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp && op_i[6:4] == 3'd4 && rs_data_i[4]) |=> (wr0_en_o && wr0_data_o == '0));

  p_lslor_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp && op_i[6:4] == 3'd3 && op_i[11:9] == 3'(PAIR_LO))
    |=> (wr0_en_o && wr1_en_o && wr0_addr_o == 3'(PAIR_LO) && wr1_addr_o == 3'(PAIR_LO + 1)));

  p_lsror_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp && op_i[6:4] == 3'd5 && op_i[11:9] == 3'(PAIR_LO + 1))
    |=> (wr0_en_o && wr1_en_o && wr0_addr_o == 3'(PAIR_LO + 1) && wr1_addr_o == 3'(PAIR_LO)));

  p_unimpl_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimpl_o |-> (!wr0_en_o && !wr1_en_o));

  p_odd_types_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp && (op_i[6:4] < 3'd2 || op_i[6:4] > 3'd5)) |=> unimpl_o);

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wr0_en_o && !wr1_en_o && !unimpl_o));
endmodule

bind pair_shift_unit pshift_chk #(.DATA_W(DATA_W), .PAIR_LO(PAIR_LO)) u_chk (.*);

// File: tb/sim_pair_shift_unit.sv
`timescale 1ns/1ps
module sim_pair_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] op = '0;
  logic [2:0]  rd_addr, rs_addr, nb_addr;
  logic [15:0] rd_data = '0, rs_data = '0, nb_data = '0;
  logic        wr0_en, wr1_en, unimpl;
  logic [2:0]  wr0_addr, wr1_addr;
  logic [15:0] wr0_data, wr1_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pair_shift_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .rd_addr_o(rd_addr), .rs_addr_o(rs_addr), .nb_addr_o(nb_addr),
    .rd_data_i(rd_data), .rs_data_i(rs_data), .nb_data_i(nb_data),
    .wr0_en_o(wr0_en), .wr0_addr_o(wr0_addr), .wr0_data_o(wr0_data),
    .wr1_en_o(wr1_en), .wr1_addr_o(wr1_addr), .wr1_data_o(wr1_data),
    .unimpl_o(unimpl)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s op=%h actual=%h expected=%h", req, what, op, act, exp);
    end
  endtask

  function automatic string tag_of(int kind, int rd);
    if (kind == 2) return "R2";
    if (kind == 4) return "R3";
    if (kind == 3) return (rd == 3) ? "R4" : "R6";
    if (kind == 5) return (rd == 4) ? "R5" : "R6";
    return "R7";
  endfunction

  // drive one strobe at negedge, check the registered result one edge later
  task automatic run_op(int kind, int rd, int rs, int amt, logic [15:0] d, logic [15:0] nb,
                        logic [10:0] rs_hi);
    logic [31:0] lw, rw;
    logic [15:0] e0d, e1d;
    logic        e0, e1, eu;
    logic [2:0]  e1a;
    string       t;
    op      = {4'hE, 3'(rd), 1'b1, 1'b0, 3'(kind), 1'b1, 3'(rs)};
    rd_data = d;
    nb_data = nb;
    rs_data = {rs_hi, 5'(amt)};
    valid   = 1'b1;
    t  = tag_of(kind, rd);
    lw = {16'h0, d} << amt;
    rw = {d, 16'h0} >> amt;
    e0 = 0; e1 = 0; eu = 0; e0d = '0; e1d = '0;
    e1a = (kind == 5) ? 3'(rd - 1) : 3'(rd + 1);
    case (kind)
      2: begin e0 = 1; e0d = lw[15:0]; end
      4: begin e0 = 1; e0d = rw[31:16]; end
      3: if (rd == 3) begin e0 = 1; e1 = 1; e0d = lw[15:0]; e1d = nb | lw[31:16]; end
         else eu = 1;
      5: if (rd == 4) begin e0 = 1; e1 = 1; e0d = rw[31:16]; e1d = nb | rw[15:0]; end
         else eu = 1;
      default: eu = 1;
    endcase
    #1;
    chk("R10", "rd_addr", 64'(rd_addr), 64'(rd));
    chk("R10", "rs_addr", 64'(rs_addr), 64'(rs));
    chk("R10", "nb_addr", 64'(nb_addr), 64'(e1a));
    @(negedge clk);
    chk(t, "wr0_en", 64'(wr0_en), 64'(e0));
    chk(t, "wr1_en", 64'(wr1_en), 64'(e1));
    chk(t, "unimpl", 64'(unimpl), 64'(eu));
    if (e0) begin
      chk(t, "wr0_addr", 64'(wr0_addr), 64'(rd));
      chk(t, "wr0_data", 64'(wr0_data), 64'(e0d));
    end
    if (e1) begin
      chk(t, "wr1_addr", 64'(wr1_addr), 64'(e1a));
      chk(t, "wr1_data", 64'(wr1_data), 64'(e1d));
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [3];
    logic [15:0] base;
    // R9: reset state, with a strobe held during reset
    valid = 1'b1;
    op    = 16'hE728;
    repeat (2) @(negedge clk);
    chk("R9", "wr0_en", 64'(wr0_en), 64'd0);
    chk("R9", "wr1_en", 64'(wr1_en), 64'd0);
    chk("R9", "unimpl", 64'(unimpl), 64'd0);
    chk("R9", "wr0_data", 64'(wr0_data), 64'd0);
    chk("R9", "wr1_data", 64'(wr1_data), 64'd0);
    valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // full sweep
    for (int kind = 0; kind < 8; kind++)
      for (int rd = 0; rd < 8; rd++)
        for (int amt = 0; amt < 32; amt++) begin
          pats[0] = 16'hFFFF;
          pats[1] = 16'h8001;
          pats[2] = 16'hA5C3 ^ 16'(amt * 37 + rd * 11);
          for (int p = 0; p < 3; p++)
            run_op(kind, rd, (rd + amt) % 8, amt, pats[p],
                   16'h0F00 ^ 16'(p * 257 + amt), 11'(amt * 73 + p * 5 + 1));
        end

    // R8: no strobe, matching opcode present
    valid = 1'b0;
    op    = 16'hE728;
    rs_data = 16'd3;
    @(negedge clk);
    chk("R8", "idle wr0_en", 64'(wr0_en), 64'd0);
    chk("R8", "idle wr1_en", 64'(wr1_en), 64'd0);
    chk("R8", "idle unimpl", 64'(unimpl), 64'd0);

    // R1: flip each mask bit of a valid lslor opcode
    base = 16'hE738;
    for (int b = 0; b < 16; b++) begin
      if (16'hF188 & (16'h1 << b)) begin
        op    = base ^ (16'h1 << b);
        valid = 1'b1;
        @(negedge clk);
        chk("R1", "foreign wr0_en", 64'(wr0_en), 64'd0);
        chk("R1", "foreign wr1_en", 64'(wr1_en), 64'd0);
        chk("R1", "foreign unimpl", 64'(unimpl), 64'd0);
      end
    end
    valid = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule